// File: doc/BRIEF.md
# Program Memory Load/Store Unit

This unit carries out the program-memory transfer instructions of a small 8-bit processor core. A byte-wide load reads from a program store that is organised in 16-bit words. The byte address comes from a 16-bit Z pointer. The extended forms widen that pointer with an 8-bit page register into a 24-bit address. The store form writes the register pair R1:R0 as one word. Some forms also advance the pointer after the transfer.

The decoder raises `start` for one cycle with an operation code, a destination register index, the current pointer and page values and the contents of R0 and R1. The unit captures all of these and holds `busy` for the length of the operation. It drives a simple synchronous memory port. On the last busy cycle it returns its results: a register write and/or new pointer and page values with a write strobe. No status flags are produced.

Top module: `pmls_unit`

## Requirements
- R1: After reset, and whenever reset is asserted during an operation, `busy`, `rf_we`, `ptr_we`, `pm_re` and `pm_we` are all 0.
- R2: The `op` encoding is 0 = load, 1 = load with post-increment, 2 = extended load, 3 = extended load with post-increment, 4 = extended load into R0, 5 = store, 6 = store with post-increment. A load keeps `busy` high for exactly 3 cycles. `pm_re` is high in the first of them. `rf_we` is high for one cycle, the last, and only then.
- R3: A store keeps `busy` high for exactly 4 cycles. `pm_we` is high in the second of them, with `pm_wdata` = {R1,R0} and `pm_addr` = {page,Z} >> 1. It never asserts `rf_we`.
- R4: The word address on `pm_addr` is the byte address shifted right by one. Byte-address bit 0 selects the low byte (0) or the high byte (1) of the returned word.
- R5: Codes 0 and 1 address with Z alone, and the upper 8 address bits are zero. Code 1 then returns Z+1 modulo 2^16 with the page unchanged.
- R6: Codes 2 to 4 address with {page,Z}. Code 3 returns {page,Z}+1 modulo 2^24, so a carry out of Z increments the page.
- R7: Code 4 writes its byte to register index 0 whatever `rd_sel` holds.
- R8: Code 6 returns Z+2 modulo 2^16 with the page unchanged, after the write.
- R9: `start` is ignored while `busy` is high. Code 7 is ignored: no busy, no strobes.
- R10: A post-increment load whose destination is register 30 or 31 still updates the pointer but performs no register write. A load without increment to those registers writes normally. The unit never stays busy longer than 4 cycles.
- R11: `ptr_we` pulses exactly once, in the last busy cycle, for codes 1, 3 and 6, and never for the other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code |
| rd_sel | input | 5 | Destination register index |
| rf_r0 | input | 8 | Current contents of R0 |
| rf_r1 | input | 8 | Current contents of R1 |
| z_in | input | 16 | Current Z pointer |
| page_in | input | 8 | Current page register |
| busy | output | 1 | Operation in progress |
| rf_we | output | 1 | Register write strobe |
| rf_wsel | output | 5 | Register write index |
| rf_wdata | output | 8 | Register write data |
| ptr_we | output | 1 | Pointer/page write strobe |
| z_out | output | 16 | New Z value |
| page_out | output | 8 | New page value |
| pm_addr | output | 23 | Program-memory word address |
| pm_re | output | 1 | Program-memory read enable |
| pm_rdata | input | 16 | Program-memory read word (one cycle after `pm_re`) |
| pm_we | output | 1 | Program-memory write enable |
| pm_wdata | output | 16 | Program-memory write word |

## Verification
The hardest situations to reach are those where two updates compete or a carry crosses a register boundary. In one, a post-increment load names a register that is part of Z itself. In the other, the 24-bit increment carries from Z into the page or wraps the whole pointer to zero. The vector table places Z at 0xFFFF with pages 0x3C and 0xFF. Directed cases issue an incrementing load to register 30 and a plain load to register 31, and check the register write strobe and the pointer outputs separately. A second `start` raised during a busy load and a reset pulled mid-operation show that the sequencer can neither be re-entered nor left hanging.

// File: rtl/pmls_pkg.sv
package pmls_pkg;

   typedef enum logic [2:0] {
      PM_LD      = 3'd0,
      PM_LD_INC  = 3'd1,
      PM_XLD     = 3'd2,
      PM_XLD_INC = 3'd3,
      PM_XLD_R0  = 3'd4,
      PM_ST      = 3'd5,
      PM_ST_INC  = 3'd6,
      PM_NONE    = 3'd7
   } pm_op_e;

   function automatic logic op_is_store(pm_op_e o);
      return (o == PM_ST) || (o == PM_ST_INC);
   endfunction

   function automatic logic op_uses_page(pm_op_e o);
      return (o == PM_XLD) || (o == PM_XLD_INC) || (o == PM_XLD_R0) ||
             (o == PM_ST)  || (o == PM_ST_INC);
   endfunction

   function automatic logic op_steps(pm_op_e o);
      return (o == PM_LD_INC) || (o == PM_XLD_INC) || (o == PM_ST_INC);
   endfunction

endpackage

// File: rtl/pmls_ptr.sv
module pmls_ptr
   import pmls_pkg::*;
#(
   parameter int ZW     = 16,
   parameter int PW     = 8,
   parameter bit EXT_EN = 1'b1
) (
   input  pm_op_e           op,
   input  logic [ZW-1:0]    z,
   input  logic [PW-1:0]    page,
   output logic [ZW+PW-1:0] byte_addr,
   output logic [ZW-1:0]    z_nxt,
   output logic [PW-1:0]    page_nxt,
   output logic             upd
);
   localparam int AW = ZW + PW;

   logic [PW-1:0] page_eff;
   logic [AW-1:0] wide_inc;

   generate
      if (EXT_EN) begin : g_ext
         assign page_eff = page;
      end else begin : g_noext
         assign page_eff = '0;
      end
   endgenerate

   assign byte_addr = {(op_uses_page(op) ? page_eff : {PW{1'b0}}), z};
   assign wide_inc  = {page_eff, z} + AW'(1);
   assign upd       = op_steps(op);

   always_comb begin
      z_nxt    = z;
      page_nxt = page;
      unique case (op)
         PM_LD_INC: z_nxt = z + ZW'(1);
         PM_XLD_INC: begin
            if (EXT_EN) begin
               z_nxt    = wide_inc[ZW-1:0];
               page_nxt = wide_inc[AW-1:ZW];
            end else begin
               z_nxt    = z + ZW'(1);
            end
         end
         PM_ST_INC: z_nxt = z + ZW'(2);
         default: ;
      endcase
   end
endmodule

// File: rtl/pmls_bytesel.sv
module pmls_bytesel #(
   parameter int DW = 16,
   localparam int LANES = DW / 8,
   localparam int SELW  = $clog2(LANES)
) (
   input  logic [DW-1:0]   word,
   input  logic [SELW-1:0] sel,
   output logic [7:0]      byte_o
);
   logic [7:0] lane [LANES];

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane[i] = word[8*i +: 8];
      end
   endgenerate

   assign byte_o = lane[sel];
endmodule

// File: rtl/pmls_seq.sv
module pmls_seq
   import pmls_pkg::*;
#(
   parameter int LD_CYC = 3,
   parameter int ST_CYC = 4,
   localparam int MAXC = (LD_CYC > ST_CYC) ? LD_CYC : ST_CYC,
   localparam int CW   = $clog2(MAXC + 1)
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  pm_op_e op,
   output logic   accept,
   output logic   busy,
   output logic   is_st,
   output logic   rd_issue,
   output logic   rd_capture,
   output logic   wr_issue,
   output logic   last
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] len;

   assign accept = start && !busy && (op != PM_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         is_st <= 1'b0;
         cnt   <= '0;
         len   <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         is_st <= op_is_store(op);
         cnt   <= CW'(1);
         len   <= op_is_store(op) ? CW'(ST_CYC) : CW'(LD_CYC);
      end else if (busy) begin
         if (cnt == len) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt  <= cnt + CW'(1);
         end
      end
   end

   assign rd_issue   = busy && !is_st && (cnt == CW'(1));
   assign rd_capture = busy && !is_st && (cnt == CW'(2));
   assign wr_issue   = busy &&  is_st && (cnt == CW'(2));
   assign last       = busy && (cnt == len);
endmodule

// File: rtl/pmls_unit.sv
module pmls_unit
   import pmls_pkg::*;
#(
   parameter int ZW     = 16,
   parameter int PW     = 8,
   parameter int DW     = 16,
   parameter int RIDX_W = 5,
   parameter int Z_IDX  = 30,
   parameter int LD_CYC = 3,
   parameter int ST_CYC = 4,
   parameter bit EXT_EN = 1'b1,
   localparam int AW    = ZW + PW,
   localparam int SELW  = $clog2(DW / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [RIDX_W-1:0] rd_sel,
   input  logic [7:0]        rf_r0,
   input  logic [7:0]        rf_r1,
   input  logic [ZW-1:0]     z_in,
   input  logic [PW-1:0]     page_in,
   output logic              busy,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_wsel,
   output logic [7:0]        rf_wdata,
   output logic              ptr_we,
   output logic [ZW-1:0]     z_out,
   output logic [PW-1:0]     page_out,
   output logic [AW-SELW-1:0] pm_addr,
   output logic              pm_re,
   input  logic [DW-1:0]     pm_rdata,
   output logic              pm_we,
   output logic [DW-1:0]     pm_wdata
);
   generate
      if ((DW % 8) != 0 || DW < 16) begin : g_bad_dw
         $error("pmls_unit: DW must be a multiple of 8 and at least 16");
      end
      if (LD_CYC < 3 || ST_CYC < 2) begin : g_bad_cyc
         $error("pmls_unit: LD_CYC must be >= 3 and ST_CYC >= 2");
      end
      if (Z_IDX + 1 >= (1 << RIDX_W)) begin : g_bad_zidx
         $error("pmls_unit: Z_IDX pair must fit the register index");
      end
   endgenerate

   pm_op_e            op_in;
   pm_op_e            op_q;
   logic [RIDX_W-1:0] rd_q;
   logic [ZW-1:0]     z_q;
   logic [PW-1:0]     page_q;
   logic [15:0]       pair_q;
   logic [7:0]        dat_q;

   logic              accept, is_st, rd_issue, rd_capture, wr_issue, last;
   logic [AW-1:0]     byte_addr;
   logic              upd, clash;
   logic [7:0]        sel_byte;

   assign op_in = pm_op_e'(op);

   pmls_seq #(.LD_CYC(LD_CYC), .ST_CYC(ST_CYC)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op         (op_in),
      .accept     (accept),
      .busy       (busy),
      .is_st      (is_st),
      .rd_issue   (rd_issue),
      .rd_capture (rd_capture),
      .wr_issue   (wr_issue),
      .last       (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= PM_NONE;
         rd_q   <= '0;
         z_q    <= '0;
         page_q <= '0;
         pair_q <= '0;
      end else if (accept) begin
         op_q   <= op_in;
         rd_q   <= rd_sel;
         z_q    <= z_in;
         page_q <= page_in;
         pair_q <= {rf_r1, rf_r0};
      end
   end

   pmls_ptr #(.ZW(ZW), .PW(PW), .EXT_EN(EXT_EN)) i_ptr (
      .op        (op_q),
      .z         (z_q),
      .page      (page_q),
      .byte_addr (byte_addr),
      .z_nxt     (z_out),
      .page_nxt  (page_out),
      .upd       (upd)
   );

   pmls_bytesel #(.DW(DW)) i_sel (
      .word   (pm_rdata),
      .sel    (byte_addr[SELW-1:0]),
      .byte_o (sel_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dat_q <= '0;
      else if (rd_capture) dat_q <= sel_byte;
   end

   // pointer update wins when the incremented pointer overlaps the target
   assign clash = op_steps(op_q) &&
                  ((rd_q == RIDX_W'(Z_IDX)) || (rd_q == RIDX_W'(Z_IDX + 1)));

   assign pm_addr  = byte_addr[AW-1:SELW];
   assign pm_re    = rd_issue;
   assign pm_we    = wr_issue;
   assign pm_wdata = DW'(pair_q);
   assign rf_wsel  = (op_q == PM_XLD_R0) ? '0 : rd_q;
   assign rf_wdata = dat_q;
   assign rf_we    = last && !is_st && !clash;
   assign ptr_we   = last && upd;
endmodule

// File: rtl/pmls_unit_chk.sv
module pmls_unit_chk #(
   parameter int LD_CYC = 3,
   parameter int ST_CYC = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [2:0] op,
   input logic       busy,
   input logic       rf_we,
   input logic       ptr_we,
   input logic       pm_re,
   input logic       pm_we
);
   localparam int MAXC = (LD_CYC > ST_CYC) ? LD_CYC : ST_CYC;

   int busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op != 3'd7) |=> busy);
   assert_wb_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !busy);
   assert_wb_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> busy);
   assert_ptr_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |=> !busy);
   assert_mem_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(pm_we && pm_re));
   assert_store_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pm_we |-> !rf_we);
   assert_code7_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op == 3'd7) |=> !busy);
   assert_no_lockup_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= MAXC);
endmodule

bind pmls_unit pmls_unit_chk #(.LD_CYC(LD_CYC), .ST_CYC(ST_CYC)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .op     (op),
   .busy   (busy),
   .rf_we  (rf_we),
   .ptr_we (ptr_we),
   .pm_re  (pm_re),
   .pm_we  (pm_we)
);

// File: tb/test_pmls_unit.sv
module test_pmls_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd7;
   logic [4:0]  rd_sel = '0;
   logic [7:0]  rf_r0 = '0, rf_r1 = '0;
   logic [15:0] z_in = '0;
   logic [7:0]  page_in = '0;
   logic        busy, rf_we, ptr_we, pm_re, pm_we;
   logic [4:0]  rf_wsel;
   logic [7:0]  rf_wdata, page_out;
   logic [15:0] z_out, pm_wdata;
   logic [15:0] pm_rdata = '0;
   logic [22:0] pm_addr;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmls_unit i_pmls_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rd_sel(rd_sel),
      .rf_r0(rf_r0), .rf_r1(rf_r1), .z_in(z_in), .page_in(page_in),
      .busy(busy), .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
      .ptr_we(ptr_we), .z_out(z_out), .page_out(page_out),
      .pm_addr(pm_addr), .pm_re(pm_re), .pm_rdata(pm_rdata),
      .pm_we(pm_we), .pm_wdata(pm_wdata)
   );

   function automatic logic [15:0] mem_word(input logic [22:0] a);
      return {a[15:8] + {1'b0, a[22:16]} + 8'h3C, a[7:0] ^ 8'h5A};
   endfunction

   always_ff @(posedge clk) if (pm_re) pm_rdata <= mem_word(pm_addr);

   // {op, rd, z, page, r0, r1, expected z, expected page}
   localparam logic [71:0] VEC [10] = '{
      {3'd0, 5'd5,  16'h1234, 8'h77, 8'h00, 8'h00, 16'h1234, 8'h77},
      {3'd0, 5'd6,  16'h1235, 8'h77, 8'h00, 8'h00, 16'h1235, 8'h77},
      {3'd1, 5'd7,  16'hFFFF, 8'h12, 8'h00, 8'h00, 16'h0000, 8'h12},
      {3'd2, 5'd8,  16'h00FE, 8'h3C, 8'h00, 8'h00, 16'h00FE, 8'h3C},
      {3'd3, 5'd9,  16'hFFFF, 8'h3C, 8'h00, 8'h00, 16'h0000, 8'h3D},
      {3'd3, 5'd10, 16'h0101, 8'hFF, 8'h00, 8'h00, 16'h0102, 8'hFF},
      {3'd4, 5'd17, 16'h4443, 8'h05, 8'h00, 8'h00, 16'h4443, 8'h05},
      {3'd5, 5'd0,  16'h2000, 8'h01, 8'hAB, 8'hCD, 16'h2000, 8'h01},
      {3'd6, 5'd0,  16'hFFFE, 8'h02, 8'h11, 8'h22, 16'h0000, 8'h02},
      {3'd3, 5'd12, 16'hFFFF, 8'hFF, 8'h00, 8'h00, 16'h0000, 8'h00}
   };

   // observations of one operation
   int          n_busy, n_rf, n_ptr, n_re, n_we, rf_cyc, ptr_cyc, we_cyc;
   logic [22:0] obs_raddr, obs_waddr;
   logic [15:0] obs_wdata, obs_z;
   logic [7:0]  obs_rdata, obs_page;
   logic [4:0]  obs_wsel;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [2:0] o, input logic [4:0] rd, input logic [15:0] z,
                         input logic [7:0] pg, input logic [7:0] r0, input logic [7:0] r1,
                         input bit poke);
      n_busy = 0; n_rf = 0; n_ptr = 0; n_re = 0; n_we = 0;
      rf_cyc = 0; ptr_cyc = 0; we_cyc = 0;
      @(negedge clk);
      start = 1'b1; op = o; rd_sel = rd; z_in = z; page_in = pg; rf_r0 = r0; rf_r1 = r1;
      @(posedge clk);
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk);
         if (busy) n_busy++;
         if (pm_re) begin n_re++; obs_raddr = pm_addr; end
         if (pm_we) begin n_we++; we_cyc = k; obs_waddr = pm_addr; obs_wdata = pm_wdata; end
         if (rf_we) begin n_rf++; rf_cyc = k; obs_rdata = rf_wdata; obs_wsel = rf_wsel; end
         if (ptr_we) begin n_ptr++; ptr_cyc = k; obs_z = z_out; obs_page = page_out; end
         if (poke && k == 1) begin
            start = 1'b1; op = 3'd5; z_in = 16'h0F0F;
         end else begin
            start = 1'b0; op = 3'd7;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "strobes in reset", {rf_we, ptr_we, pm_re, pm_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", busy, 0);

      // table walk
      foreach (VEC[i]) begin
         automatic logic [71:0] v = VEC[i];
         automatic logic [2:0]  o = v[71:69];
         automatic logic [4:0]  rd = v[68:64];
         automatic logic [15:0] z = v[63:48];
         automatic logic [7:0]  pg = v[47:40];
         automatic logic [7:0]  r0 = v[39:32];
         automatic logic [7:0]  r1 = v[31:24];
         automatic logic [15:0] ez = v[23:8];
         automatic logic [7:0]  ep = v[7:0];
         automatic bit          st = (o == 3'd5 || o == 3'd6);
         automatic bit          steps = (o == 3'd1 || o == 3'd3 || o == 3'd6);
         automatic logic [23:0] ba = (o >= 3'd2) ? {pg, z} : {8'h00, z};
         automatic logic [15:0] w = mem_word(ba[23:1]);
         automatic logic [7:0]  eb = ba[0] ? w[15:8] : w[7:0];
         run_op(o, rd, z, pg, r0, r1, 1'b0);
         if (st) begin
            chk("R3", "store busy cycles", n_busy, 4);
            chk("R3", "store write cycle", we_cyc, 2);
            chk("R3", "store word address", obs_waddr, ba[23:1]);
            chk("R3", "store data", obs_wdata, {r1, r0});
            chk("R3", "store no reg write", n_rf, 0);
         end else begin
            chk("R2", "load busy cycles", n_busy, 3);
            chk("R2", "single read", n_re, 1);
            chk("R2", "reg write on last cycle", rf_cyc, 3);
            chk(o >= 3'd2 ? "R6" : "R5", "read word address R4", obs_raddr, ba[23:1]);
            chk("R4", "selected byte", obs_rdata, eb);
            chk("R7", "write index", obs_wsel, (o == 3'd4) ? 5'd0 : rd);
         end
         chk("R11", "pointer write count", n_ptr, steps ? 1 : 0);
         if (steps) begin
            chk("R11", "pointer write cycle", ptr_cyc, st ? 4 : 3);
            chk(o == 3'd6 ? "R8" : (o == 3'd3 ? "R6" : "R5"), "new Z", obs_z, ez);
            chk(o == 3'd6 ? "R8" : (o == 3'd3 ? "R6" : "R5"), "new page", obs_page, ep);
         end
      end

      // R9: start while busy is ignored
      run_op(3'd0, 5'd3, 16'h0042, 8'h00, 8'h00, 8'h00, 1'b1);
      chk("R9", "busy cycles with second start", n_busy, 3);
      chk("R9", "no write from ignored store", n_we, 0);
      chk("R9", "one reg write", n_rf, 1);

      // R9: code 7 ignored
      run_op(3'd7, 5'd3, 16'h0042, 8'h00, 8'h00, 8'h00, 1'b0);
      chk("R9", "code 7 busy", n_busy, 0);
      chk("R9", "code 7 strobes", n_rf + n_ptr + n_re + n_we, 0);

      // R10: post-increment onto pointer register
      run_op(3'd1, 5'd30, 16'h00FF, 8'h00, 8'h00, 8'h00, 1'b0);
      chk("R10", "clash reg write suppressed", n_rf, 0);
      chk("R10", "clash pointer write", n_ptr, 1);
      chk("R10", "clash new Z", obs_z, 16'h0100);
      chk("R10", "clash busy cycles", n_busy, 3);
      run_op(3'd0, 5'd31, 16'h0010, 8'h00, 8'h00, 8'h00, 1'b0);
      chk("R10", "plain load to 31 writes", n_rf, 1);
      chk("R10", "plain load to 31 index", obs_wsel, 5'd31);

      // R1: reset during an operation
      @(negedge clk);
      start = 1'b1; op = 3'd5; z_in = 16'h1000;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; op = 3'd7;
      rst_n = 1'b0;
      #1;
      chk("R1", "busy after mid-op reset", busy, 0);
      chk("R1", "strobes after mid-op reset", {rf_we, ptr_we, pm_re, pm_we}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "stays idle after reset", busy, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule